// File: doc/BRIEF.md
# Multi-Target SPI Master with Per-Target Clock Modes

This block is an SPI master that serves several targets. Each target has its own active-low select line. For each target the block holds a configuration entry with three settings: idle clock level, sampling phase and clock divider. A host writes these entries through a separate configuration port.

A host starts a transfer by raising a request while the block is ready. The request carries a target index and a byte. The block then snapshots that target's entry, parks the serial clock at the target's idle level and pulls only that target's select low. It shifts the byte out most significant bit first and shifts the incoming line in at the same time. At the end it releases the select and pulses done with the received byte.

The block reconfigures itself on every new transfer. Targets with different modes and rates can therefore be addressed back to back without any host action in between. There is no acknowledgement from the target: a transfer to an absent target completes normally and returns whatever level the input line rests at.

Top module: `spi_tgt_master`

## Requirements
- R1: After reset, ready is 1, every select line is 1, the serial clock is 0, done is 0, the received byte is 0. Every configuration entry reads as idle-low clock, phase 0, divider 0.
- R2: A request is taken only on a cycle with ready high. Ready stays low from the cycle after acceptance until the cycle in which done is high. A request raised while ready is low has no effect.
- R3: Between acceptance and done, exactly the select line whose bit position equals the requested index is 0 and it does not change. At all other times all select lines are 1.
- R4: In the cycle after acceptance, the serial clock takes the target's stored idle level. It holds that level whenever the block is ready.
- R5: Eight bits go out MSB first on the output line while eight bits are taken from the input line. With phase 0, input is sampled on the leading clock edge and output changes on the trailing edge; the first bit is valid when select falls. With phase 1, output changes on the leading edge and input is sampled on the trailing edge.
- R6: A half clock period lasts divider+1 cycles. Select leads the first edge by one half period, sixteen edges follow one half period apart, and select rises one half period after the last edge. Done is high exactly 17*(divider+1) cycles after the acceptance edge.
- R7: Done is high for one cycle. The received byte updates only when done is high and holds its value until the next done.
- R8: A configuration write changes that target's entry for later transfers. A write addressed to the target of the transfer in progress is dropped. Writes to other targets still land.
- R9: A transfer completes with the same timing whether or not a target drives the input line. With the line resting high, the received byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| tgt_i | input | IDX_W | Target index of the request |
| tx_i | input | DATA_W | Byte to send |
| ready_o | output | 1 | Block can take a request |
| done_o | output | 1 | One-cycle completion pulse |
| rx_o | output | DATA_W | Received byte, valid with done and held |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Target entry to write |
| cfg_cpol_i | input | 1 | Idle clock level for the entry |
| cfg_cpha_i | input | 1 | Sampling phase for the entry |
| cfg_div_i | input | DIV_W | Half-period divider for the entry |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to targets |
| miso_i | input | 1 | Serial data from targets |
| cs_n_o | output | N_TGT | Active-low select, one per target |

## Verification
Select and clock level are due one cycle after the acceptance edge. The target model samples them on the following falling clock edge and checks the idle level there. Each done is due 17*(divider+1) cycles after acceptance. The driver timestamps acceptance and pushes the expected item; the monitor pops it on the done pulse and compares the elapsed cycle count, the received byte, the byte captured by the target model and the selected index. The held received byte is checked several cycles after the last pulse. A write dropped while its target is busy is shown by the following transfer's timing and idle level.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    parameter int unsigned DIV_W = 8;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
    } tcfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} st_e;
endpackage

// File: rtl/spi_tgt_cfg_bank.sv
module spi_tgt_cfg_bank
    import spi_tgt_pkg::*;
#(
    parameter int N_TGT = 4,
    localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  tcfg_t                  wdata_i,
    input  logic                   lock_i,
    input  logic [IDX_W-1:0]       lock_idx_i,
    output tcfg_t [N_TGT-1:0]      cfg_o
);
    for (genvar g = 0; g < N_TGT; g++) begin : g_ent
        tcfg_t ent_d, ent_q;
        logic  hit;

        always_comb begin
            hit   = we_i && (idx_i == IDX_W'(g)) && !(lock_i && (lock_idx_i == IDX_W'(g)));
            ent_d = hit ? wdata_i : ent_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign cfg_o[g] = ent_q;
    end
endmodule

// File: rtl/spi_tgt_tick.sv
module spi_tgt_tick
    import spi_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] load_div_i,
    input  logic [DIV_W-1:0] run_div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_div_i;
        else if (run_i) begin
            if (cnt_q == '0)    cnt_d = run_div_i;
            else                cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/spi_tgt_master.sv
module spi_tgt_master
    import spi_tgt_pkg::*;
#(
    parameter int N_TGT  = 4,
    parameter int DATA_W = 8,
    localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1,
    localparam int EW    = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [IDX_W-1:0]  tgt_i,
    input  logic [DATA_W-1:0] tx_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [N_TGT-1:0]  cs_n_o
);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DATA_W - 1);

    typedef struct packed {
        st_e               st;
        tcfg_t             cfg;
        logic [IDX_W-1:0]  tgt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic [EW-1:0]     edge_n;
        logic              sclk;
        logic              mosi;
        logic [N_TGT-1:0]  cs_n;
        logic              done;
        logic [DATA_W-1:0] rx_out;
    } reg_t;

    reg_t              r_q, r_d;
    tcfg_t [N_TGT-1:0] cfg_all;
    tcfg_t             sel_cfg;
    tcfg_t             wcfg;
    logic              accept, tick, lead;

    assign wcfg = '{cpol: cfg_cpol_i, cpha: cfg_cpha_i, div: cfg_div_i};

    spi_tgt_cfg_bank #(.N_TGT(N_TGT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .idx_i      (cfg_idx_i),
        .wdata_i    (wcfg),
        .lock_i     (r_q.st != ST_IDLE),
        .lock_idx_i (r_q.tgt),
        .cfg_o      (cfg_all)
    );

    assign sel_cfg = cfg_all[tgt_i];
    assign accept  = (r_q.st == ST_IDLE) && req_i;

    spi_tgt_tick u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .run_i      (r_q.st != ST_IDLE),
        .load_div_i (sel_cfg.div),
        .run_div_i  (r_q.cfg.div),
        .tick_o     (tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        lead     = (r_q.edge_n[0] == 1'b0);
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st          = ST_LEAD;
                    r_d.cfg         = sel_cfg;
                    r_d.tgt         = tgt_i;
                    r_d.sh          = tx_i;
                    r_d.rx          = '0;
                    r_d.edge_n      = '0;
                    r_d.sclk        = sel_cfg.cpol;
                    r_d.mosi        = sel_cfg.cpha ? 1'b0 : tx_i[DATA_W-1];
                    r_d.cs_n        = '1;
                    r_d.cs_n[tgt_i] = 1'b0;
                end
            end
            ST_LEAD, ST_SHIFT: begin
                if (tick) begin
                    r_d.sclk = ~r_q.sclk;
                    if (lead != r_q.cfg.cpha) begin
                        r_d.rx = {r_q.rx[DATA_W-2:0], miso_i};
                    end else if (r_q.cfg.cpha) begin
                        r_d.mosi = r_q.sh[DATA_W-1];
                        r_d.sh   = r_q.sh << 1;
                    end else begin
                        r_d.mosi = r_q.sh[DATA_W-2];
                        r_d.sh   = r_q.sh << 1;
                    end
                    r_d.edge_n = r_q.edge_n + 1'b1;
                    r_d.st     = (r_q.edge_n == LAST_EDGE) ? ST_TRAIL : ST_SHIFT;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    r_d.st     = ST_IDLE;
                    r_d.cs_n   = '1;
                    r_d.sclk   = r_q.cfg.cpol;
                    r_d.mosi   = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.rx_out = r_q.rx;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o = (r_q.st == ST_IDLE);
    assign done_o  = r_q.done;
    assign rx_o    = r_q.rx_out;
    assign sclk_o  = r_q.sclk;
    assign mosi_o  = r_q.mosi;
    assign cs_n_o  = r_q.cs_n;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
    parameter int N_TGT  = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rx_o,
    input logic              sclk_o,
    input logic [N_TGT-1:0]  cs_n_o
);
    AST_ONE_SELECT:    assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n_o) <= 1);                       // R3
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) ready_o |-> (&cs_n_o));                          // R3
    AST_SELECT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!ready_o && $past(!ready_o)) |-> $stable(cs_n_o)); // R3
    AST_DONE_READY:    assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ready_o);                             // R2
    AST_SCLK_PARKED:   assert property (@(posedge clk) disable iff (!rst_n) (ready_o && $past(ready_o)) |-> $stable(sclk_o)); // R4
    AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);                             // R7
    AST_RX_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(rx_o));                      // R7
endmodule

bind spi_tgt_master spi_tgt_chk #(.N_TGT(N_TGT), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ready_o),
    .done_o  (done_o),
    .rx_o    (rx_o),
    .sclk_o  (sclk_o),
    .cs_n_o  (cs_n_o)
);

// File: tb/tb_spi_tgt_master.sv
module tb_spi_tgt_master;
    localparam int N  = 4;
    localparam int W  = 8;
    localparam int DW = 8;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req = 1'b0;
    logic [IW-1:0] tgt = '0;
    logic [W-1:0]  tx = '0;
    logic          ready_o, done_o, sclk_o, mosi_o, miso;
    logic [W-1:0]  rx_o;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic [N-1:0]  cs_n_o;

    spi_tgt_master #(.N_TGT(N), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tgt_i(tgt), .tx_i(tx),
        .ready_o(ready_o), .done_o(done_o), .rx_o(rx_o),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_cpol_i(cfg_cpol),
        .cfg_cpha_i(cfg_cpha), .cfg_div_i(cfg_div),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso), .cs_n_o(cs_n_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic m_cpol [N];
    logic m_cpha [N];
    int   m_div  [N];

    typedef struct {
        int       tgt;
        logic [W-1:0] tx;
        logic [W-1:0] rx;
        int       start;
        int       h;
    } exp_t;
    exp_t sb [$];

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // target model, polled on the falling clock edge
    logic         slv_en = 1'b1;
    logic [W-1:0] slv_resp = '0;
    logic         slv_miso = 1'b1;
    logic [W-1:0] slv_cap = '0;
    int           slv_sel = -1;
    assign miso = slv_en ? slv_miso : 1'b1;

    logic [N-1:0] prev_cs = '1;
    logic         prev_sclk = 1'b0;
    logic         s_pol = 1'b0, s_pha = 1'b0;
    int           bp = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((&prev_cs) && !(&cs_n_o)) begin
                slv_sel = -1;
                for (int i = 0; i < N; i++) if (!cs_n_o[i]) slv_sel = i;
                chk($countones(~cs_n_o) == 1, "R3", "select count", $countones(~cs_n_o), 1);
                s_pol   = m_cpol[slv_sel];
                s_pha   = m_cpha[slv_sel];
                chk(sclk_o == s_pol, "R4", "idle clock at select", sclk_o, s_pol);
                slv_cap = '0;
                bp      = W - 1;
                if (!s_pha) begin
                    slv_miso = slv_resp[bp];
                    bp--;
                end
            end else if (!(&cs_n_o) && (sclk_o != prev_sclk)) begin
                if ((sclk_o != s_pol) != s_pha) slv_cap = {slv_cap[W-2:0], mosi_o};
                else if (bp >= 0) begin
                    slv_miso = slv_resp[bp];
                    bp--;
                end
            end
            prev_cs   = cs_n_o;
            prev_sclk = sclk_o;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc - e.start == 17 * e.h, "R6", "cycles to done", cyc - e.start, 17 * e.h);
                chk(rx_o == e.rx, "R5", "received byte", rx_o, e.rx);
                chk(slv_cap == e.tx, "R5", "byte seen by target", slv_cap, e.tx);
                chk(slv_sel == e.tgt, "R3", "selected line", slv_sel, e.tgt);
                chk(ready_o == 1'b1, "R2", "ready with done", ready_o, 1);
            end
        end
    end

    task automatic cfg_write(int idx, bit pol, bit pha, int div, bit lands);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_cpol = pol; cfg_cpha = pha; cfg_div = DW'(div);
        @(negedge clk);
        cfg_we = 1'b0;
        if (lands) begin
            m_cpol[idx] = pol; m_cpha[idx] = pha; m_div[idx] = div;
        end
    endtask

    task automatic xfer(int t, logic [W-1:0] d, logic [W-1:0] resp, bit present);
        exp_t e;
        while (!ready_o) @(negedge clk);
        slv_resp = resp;
        slv_en   = present;
        slv_miso = 1'b1;
        req = 1'b1; tgt = IW'(t); tx = d;
        @(negedge clk);
        req = 1'b0;
        e.tgt = t; e.tx = d; e.rx = present ? resp : '1;
        e.start = cyc; e.h = m_div[t] + 1;
        sb.push_back(e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_cpol[i] = 0; m_cpha[i] = 0; m_div[i] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready_o == 1'b1, "R1", "ready", ready_o, 1);
        chk(cs_n_o == '1, "R1", "selects", cs_n_o, 4'hF);
        chk(sclk_o == 1'b0, "R1", "sclk", sclk_o, 0);
        chk(done_o == 1'b0, "R1", "done", done_o, 0);
        chk(rx_o == '0, "R1", "rx", rx_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default entry: mode 0, divider 0
        xfer(0, 8'hA5, 8'h3C, 1);
        // R8 per-target entries, all four modes
        cfg_write(1, 0, 1, 2, 1);
        cfg_write(2, 1, 0, 1, 1);
        cfg_write(3, 1, 1, 3, 1);
        xfer(1, 8'h81, 8'h7E, 1);
        xfer(2, 8'hFF, 8'h00, 1);
        xfer(3, 8'h00, 8'hFF, 1);
        // back-to-back target switching
        xfer(3, 8'h5A, 8'hC3, 1);
        xfer(0, 8'h3C, 8'h96, 1);
        xfer(2, 8'h69, 8'h01, 1);
        xfer(1, 8'h80, 8'h80, 1);

        // R2 request while busy has no effect
        xfer(1, 8'h12, 8'h34, 1);
        req = 1'b1; tgt = 2'd3; tx = 8'hEE;
        @(negedge clk);
        req = 1'b0;
        chk(cs_n_o == 4'b1101, "R2", "select during busy request", cs_n_o, 4'b1101);

        // R9 absent target
        xfer(0, 8'hC6, 8'h00, 0);

        // R8 write to active target dropped, other target lands
        xfer(2, 8'h4B, 8'hB4, 1);
        cfg_write(2, 0, 1, 7, 0);
        cfg_write(1, 1, 1, 0, 1);
        xfer(2, 8'hD2, 8'h2D, 1);
        xfer(1, 8'h0F, 8'hF0, 1);

        while (!(ready_o && sb.size() == 0)) @(negedge clk);
        // R7 received byte held after done
        repeat (5) @(negedge clk);
        chk(rx_o == 8'hF0, "R7", "held byte", rx_o, 8'hF0);
        chk(cs_n_o == '1, "R3", "selects idle", cs_n_o, 4'hF);
        chk(sclk_o == m_cpol[1], "R4", "parked clock", sclk_o, m_cpol[1]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule